// File: doc/BRIEF.md
# Floating-Point Invalid-Operation and Signed-Zero Screen

This combinational screen sits beside a floating-point arithmetic datapath. It looks at the operands of an add, subtract, multiply, divide, square root or fused multiply-add, in either single or double precision. It reports whether the combination of special values makes the operation invalid, so that the datapath must write the canonical quiet NaN. It also supplies that canonical NaN, correctly formatted for the selected precision.

For fused multiply-add it also decides when the result is an exact zero whose sign follows special rules. The datapath then writes a zero of the reported sign in place of its own arithmetic result. Negated multiply-add forms are handled by the caller, which flips the addend or factor sign bits before presenting them. NaN operands are outside the screen's job. When any operand in use is a NaN, or when the caller reports that NaN propagation has already taken the result, both flags stay low.

Top module: `fpinv_top`

## Requirements
- R1: With opcode 0 (add), two infinite operands `opA` and `opB` of opposite sign raise `invalid`; infinities of equal sign, or one finite operand, do not.
- R2: With opcode 1 (subtract), two infinite operands of equal sign raise `invalid`; infinities of opposite sign do not.
- R3: With opcode 2 (multiply), an infinity times a zero raises `invalid` in either operand order; an infinity times a nonzero finite value does not.
- R4: With opcode 3 (divide), infinity over infinity and zero over zero raise `invalid`. A zero over a nonzero value, including a subnormal, does not.
- R5: With opcode 4 (square root), `opA` with its sign bit set that is neither zero nor NaN raises `invalid`, and this includes minus infinity. Minus zero and positive operands do not.
- R6: With opcode 5 (fused multiply-add, result = `opC` + `opA`×`opB`), `invalid` is raised in two cases. The first is a factor pair of infinity and zero. The second is an infinite `opC` meeting an infinite product whose sign (XOR of the factor signs) differs from the sign of `opC`.
- R7: With opcode 5, a zero `opC` and at least one zero factor force `zeroForce`. `zeroSign` is then 1 only when `opC` is negative and the product sign is negative. `zeroSign` is 0 whenever `zeroForce` is 0, and `zeroForce` is never raised for other opcodes.
- R8: With opcode 5, a zero `opC` with nonzero, non-infinite factors and `prodRoundedZero` high forces `zeroForce`, with `zeroSign` equal to the product sign.
- R9: A NaN in any operand that the opcode uses, or `nanTaken` high, keeps both `invalid` and `zeroForce` low.
- R10: `defaultNan` is 64'h7FF8000000000000 when `dblSel` is 1, and 64'h000000007FC00000 when `dblSel` is 0. In single precision only bits 31:0 of each operand are examined.
- R11: Opcodes 6 and 7 raise neither flag, and `invalid` and `zeroForce` are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 64 | First operand / first factor / square-root radicand |
| opB | input | 64 | Second operand / second factor |
| opC | input | 64 | Addend of fused multiply-add |
| opcode | input | 3 | 0 add, 1 sub, 2 mul, 3 div, 4 sqrt, 5 fused multiply-add |
| dblSel | input | 1 | 1 = double precision, 0 = single precision in bits 31:0 |
| nanTaken | input | 1 | NaN propagation already owns the result |
| prodRoundedZero | input | 1 | Datapath's rounded multiply-add result is zero |
| invalid | output | 1 | Operation is invalid; write the default NaN |
| defaultNan | output | 64 | Canonical quiet NaN for the selected precision |
| zeroForce | output | 1 | Write a signed zero instead of the datapath result |
| zeroSign | output | 1 | Sign of the forced zero |

## Verification
Every result is due in the same cycle as its stimulus, because no register lies between any input and any output. The bench changes the inputs just after a rising clock edge and reads all four outputs at the following falling edge. By then the settled combinational value is present, and no sample can see a half-applied set of inputs. Each scenario task drives one operand pattern at a time and compares all flag outputs against values derived from the requirement text.

// File: rtl/fpinv_pkg.sv
package fpinv_pkg;

  localparam int SP_EXP_W = 8;
  localparam int SP_MAN_W = 23;
  localparam int DP_EXP_W = 11;
  localparam int DP_MAN_W = 52;
  localparam int SP_W     = 1 + SP_EXP_W + SP_MAN_W;
  localparam int DP_W     = 1 + DP_EXP_W + DP_MAN_W;
  localparam int N_OPS    = 3;

  typedef enum logic [2:0] {
    OP_ADD  = 3'd0,
    OP_SUB  = 3'd1,
    OP_MUL  = 3'd2,
    OP_DIV  = 3'd3,
    OP_SQRT = 3'd4,
    OP_FMA  = 3'd5
  } fpOp_e;

  typedef struct packed {
    logic sign;
    logic isZero;
    logic isInf;
    logic isNan;
  } opClass_t;

  typedef struct packed {
    logic raiseInvalid;
    logic forceZero;
    logic zeroNeg;
  } strobe_t;

endpackage

// File: rtl/fpinv_opclass.sv
module fpinv_opclass
  import fpinv_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23,
  localparam int W = 1 + EXP_W + MAN_W
) (
  input  logic [W-1:0] val,
  output opClass_t     cls
);

  logic [EXP_W-1:0] expField;
  logic [MAN_W-1:0] manField;
  logic expOnes;
  logic expZero;
  logic manZero;

  assign expField = val[W-2:MAN_W];
  assign manField = val[MAN_W-1:0];
  assign expOnes  = &expField;
  assign expZero  = ~|expField;
  assign manZero  = ~|manField;

  // Subnormals have a zero exponent but a nonzero fraction: not zero.
  assign cls.sign   = val[W-1];
  assign cls.isZero = expZero & manZero;
  assign cls.isInf  = expOnes & manZero;
  assign cls.isNan  = expOnes & ~manZero;

endmodule

// File: rtl/fpinv_ctrl.sv
module fpinv_ctrl
  import fpinv_pkg::*;
(
  input  logic [2:0] opcode,
  input  opClass_t   clsA,
  input  opClass_t   clsB,
  input  opClass_t   clsC,
  input  logic       nanTaken,
  input  logic       prodRoundedZero,
  output strobe_t    strobes
);

  logic [N_OPS-1:0] usedMask;
  logic [N_OPS-1:0] nanVec;
  logic anyNan;
  logic blockAll;
  logic prodNeg;
  logic prodInf;
  logic mulConflict;
  logic fmaInfConflict;
  logic exactZero;
  logic roundZero;
  logic isFma;
  logic rawInvalid;

  assign nanVec         = {clsC.isNan, clsB.isNan, clsA.isNan};
  assign prodNeg        = clsA.sign ^ clsB.sign;
  assign prodInf        = clsA.isInf | clsB.isInf;
  assign mulConflict    = (clsA.isInf & clsB.isZero) | (clsB.isInf & clsA.isZero);
  assign fmaInfConflict = clsC.isInf & prodInf & (clsC.sign != prodNeg);
  assign exactZero      = clsC.isZero & (clsA.isZero | clsB.isZero);
  assign roundZero      = clsC.isZero & prodRoundedZero & ~prodInf & ~exactZero;

  always_comb begin
    usedMask   = '0;
    rawInvalid = 1'b0;
    isFma      = 1'b0;
    case (opcode)
      OP_ADD: begin
        usedMask   = 3'b011;
        rawInvalid = clsA.isInf & clsB.isInf & (clsA.sign != clsB.sign);
      end
      OP_SUB: begin
        usedMask   = 3'b011;
        rawInvalid = clsA.isInf & clsB.isInf & (clsA.sign == clsB.sign);
      end
      OP_MUL: begin
        usedMask   = 3'b011;
        rawInvalid = mulConflict;
      end
      OP_DIV: begin
        usedMask   = 3'b011;
        rawInvalid = (clsA.isInf & clsB.isInf) | (clsA.isZero & clsB.isZero);
      end
      OP_SQRT: begin
        usedMask   = 3'b001;
        rawInvalid = clsA.sign & ~clsA.isZero;
      end
      OP_FMA: begin
        usedMask   = 3'b111;
        isFma      = 1'b1;
        rawInvalid = mulConflict | fmaInfConflict;
      end
      default: begin
        usedMask   = '0;
        rawInvalid = 1'b0;
      end
    endcase
  end

  assign anyNan   = |(usedMask & nanVec);
  assign blockAll = anyNan | nanTaken;

  always_comb begin
    strobes              = '0;
    strobes.raiseInvalid = rawInvalid & ~blockAll;
    strobes.forceZero    = isFma & ~rawInvalid & ~blockAll & (exactZero | roundZero);
    if (strobes.forceZero) begin
      strobes.zeroNeg = exactZero ? (clsC.sign & prodNeg) : prodNeg;
    end
  end

endmodule

// File: rtl/fpinv_datapath.sv
module fpinv_datapath
  import fpinv_pkg::*;
(
  input  strobe_t          strobes,
  input  logic             dblSel,
  output logic             invalid,
  output logic [DP_W-1:0]  defaultNan,
  output logic             zeroForce,
  output logic             zeroSign
);

  localparam logic [SP_W-1:0] SP_QNAN = {1'b0, {SP_EXP_W{1'b1}}, 1'b1, {(SP_MAN_W-1){1'b0}}};
  localparam logic [DP_W-1:0] DP_QNAN = {1'b0, {DP_EXP_W{1'b1}}, 1'b1, {(DP_MAN_W-1){1'b0}}};

  assign defaultNan = dblSel ? DP_QNAN : {{(DP_W-SP_W){1'b0}}, SP_QNAN};
  assign invalid    = strobes.raiseInvalid;
  assign zeroForce  = strobes.forceZero;
  assign zeroSign   = strobes.zeroNeg;

endmodule

// File: rtl/fpinv_top.sv
module fpinv_top
  import fpinv_pkg::*;
(
  input  logic [DP_W-1:0] opA,
  input  logic [DP_W-1:0] opB,
  input  logic [DP_W-1:0] opC,
  input  logic [2:0]      opcode,
  input  logic            dblSel,
  input  logic            nanTaken,
  input  logic            prodRoundedZero,
  output logic            invalid,
  output logic [DP_W-1:0] defaultNan,
  output logic            zeroForce,
  output logic            zeroSign
);

  logic [DP_W-1:0] opBus [N_OPS];
  opClass_t spCls [N_OPS];
  opClass_t dpCls [N_OPS];
  opClass_t cls   [N_OPS];
  strobe_t  strobes;

  assign opBus[0] = opA;
  assign opBus[1] = opB;
  assign opBus[2] = opC;

  for (genvar i = 0; i < N_OPS; i++) begin : g_op
    fpinv_opclass #(.EXP_W(SP_EXP_W), .MAN_W(SP_MAN_W)) i_sp (
      .val(opBus[i][SP_W-1:0]),
      .cls(spCls[i])
    );
    fpinv_opclass #(.EXP_W(DP_EXP_W), .MAN_W(DP_MAN_W)) i_dp (
      .val(opBus[i]),
      .cls(dpCls[i])
    );
    assign cls[i] = dblSel ? dpCls[i] : spCls[i];
  end

  fpinv_ctrl i_ctrl (
    .opcode         (opcode),
    .clsA           (cls[0]),
    .clsB           (cls[1]),
    .clsC           (cls[2]),
    .nanTaken       (nanTaken),
    .prodRoundedZero(prodRoundedZero),
    .strobes        (strobes)
  );

  fpinv_datapath i_datapath (
    .strobes   (strobes),
    .dblSel    (dblSel),
    .invalid   (invalid),
    .defaultNan(defaultNan),
    .zeroForce (zeroForce),
    .zeroSign  (zeroSign)
  );

endmodule

// File: rtl/fpinv_checker.sv
module fpinv_checker (
  input logic [2:0] opcode,
  input logic       nanTaken,
  input logic       invalid,
  input logic       zeroForce,
  input logic       zeroSign
);

  always_comb begin
    AST_FLAGS_EXCLUSIVE: assert (!(invalid && zeroForce))
      else $error("invalid and zeroForce together");  // R11
    AST_RESERVED_QUIET: assert (!(opcode[2:1] == 2'b11) || (!invalid && !zeroForce))
      else $error("reserved opcode raised a flag");  // R11
    AST_NANTAKEN_QUIET: assert (!nanTaken || (!invalid && !zeroForce))
      else $error("flag raised while NaN taken");  // R9
    AST_ZERO_FMA_ONLY: assert (!zeroForce || (opcode == 3'd5))
      else $error("zeroForce outside multiply-add");  // R7
    AST_SIGN_IDLE_LOW: assert (zeroForce || !zeroSign)
      else $error("zeroSign without zeroForce");  // R7
  end

endmodule

bind fpinv_top fpinv_checker i_checker (
  .opcode   (opcode),
  .nanTaken (nanTaken),
  .invalid  (invalid),
  .zeroForce(zeroForce),
  .zeroSign (zeroSign)
);

// File: tb/test_fpinv_top.sv
`timescale 1ns/1ps
module test_fpinv_top;

  logic [63:0] opA, opB, opC;
  logic [2:0]  opcode;
  logic        dblSel, nanTaken, prodRoundedZero;
  logic        invalid, zeroForce, zeroSign;
  logic [63:0] defaultNan;
  logic        clk;
  int          nChecks = 0;
  int          nFails  = 0;

  localparam logic [31:0] S_INF = 32'h7F800000, S_NINF = 32'hFF800000;
  localparam logic [31:0] S_ZERO = 32'h00000000, S_NZERO = 32'h80000000;
  localparam logic [31:0] S_ONE = 32'h3F800000, S_NONE = 32'hBF800000;
  localparam logic [31:0] S_QNAN = 32'h7FC00000, S_SNAN = 32'h7F800001, S_DEN = 32'h00000001;
  localparam logic [63:0] D_INF = 64'h7FF0000000000000, D_NINF = 64'hFFF0000000000000;
  localparam logic [63:0] D_ZERO = 64'h0, D_NZERO = 64'h8000000000000000;
  localparam logic [63:0] D_ONE = 64'h3FF0000000000000, D_NONE = 64'hBFF0000000000000;
  localparam logic [63:0] D_QNAN = 64'h7FF8000000000001;

  fpinv_top i_fpinv_top (
    .opA(opA), .opB(opB), .opC(opC), .opcode(opcode), .dblSel(dblSel),
    .nanTaken(nanTaken), .prodRoundedZero(prodRoundedZero),
    .invalid(invalid), .defaultNan(defaultNan), .zeroForce(zeroForce), .zeroSign(zeroSign)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [63:0] sp(input logic [31:0] v);
    return {32'hFFF00000, v};  // upper half must be ignored in single precision
  endfunction

  task automatic drive(input logic [2:0] op, input logic dbl, input logic [63:0] a,
                       input logic [63:0] b, input logic [63:0] c, input logic nt, input logic rz);
    @(posedge clk);
    #1;
    opcode = op; dblSel = dbl; opA = a; opB = b; opC = c; nanTaken = nt; prodRoundedZero = rz;
    @(negedge clk);
  endtask

  task automatic expect3(input string tag, input logic eInv, input logic eZf, input logic eZs);
    nChecks++;
    if ({invalid, zeroForce, zeroSign} !== {eInv, eZf, eZs}) begin
      nFails++;
      $display("FAIL %s: inv/zf/zs actual %b%b%b expected %b%b%b",
               tag, invalid, zeroForce, zeroSign, eInv, eZf, eZs);
    end
  endtask

  task automatic expectNan(input string tag, input logic [63:0] e);
    nChecks++;
    if (defaultNan !== e) begin
      nFails++;
      $display("FAIL %s: defaultNan actual %h expected %h", tag, defaultNan, e);
    end
  endtask

  task automatic t_idle;
    drive(3'd0, 1'b0, 64'h0, 64'h0, 64'h0, 1'b0, 1'b0);
    expect3("R11 idle", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_add;
    drive(3'd0, 1'b0, sp(S_INF), sp(S_NINF), 64'h0, 1'b0, 1'b0);
    expect3("R1 sp inf+-inf", 1'b1, 1'b0, 1'b0);
    drive(3'd0, 1'b1, D_NINF, D_INF, D_ZERO, 1'b0, 1'b0);
    expect3("R1 dp -inf+inf", 1'b1, 1'b0, 1'b0);
    drive(3'd0, 1'b0, sp(S_INF), sp(S_INF), 64'h0, 1'b0, 1'b0);
    expect3("R1 inf+inf", 1'b0, 1'b0, 1'b0);
    drive(3'd0, 1'b1, D_INF, D_NONE, D_ZERO, 1'b0, 1'b0);
    expect3("R1 inf+finite", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_sub;
    drive(3'd1, 1'b0, sp(S_NINF), sp(S_NINF), 64'h0, 1'b0, 1'b0);
    expect3("R2 -inf--inf", 1'b1, 1'b0, 1'b0);
    drive(3'd1, 1'b1, D_INF, D_INF, D_ZERO, 1'b0, 1'b0);
    expect3("R2 dp inf-inf", 1'b1, 1'b0, 1'b0);
    drive(3'd1, 1'b0, sp(S_INF), sp(S_NINF), 64'h0, 1'b0, 1'b0);
    expect3("R2 inf--inf", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_mul;
    drive(3'd2, 1'b0, sp(S_INF), sp(S_NZERO), 64'h0, 1'b0, 1'b0);
    expect3("R3 inf*0", 1'b1, 1'b0, 1'b0);
    drive(3'd2, 1'b1, D_ZERO, D_NINF, D_ZERO, 1'b0, 1'b0);
    expect3("R3 0*inf", 1'b1, 1'b0, 1'b0);
    drive(3'd2, 1'b1, D_INF, D_ONE, D_ZERO, 1'b0, 1'b0);
    expect3("R3 inf*1", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_div;
    drive(3'd3, 1'b0, sp(S_INF), sp(S_NINF), 64'h0, 1'b0, 1'b0);
    expect3("R4 inf/inf", 1'b1, 1'b0, 1'b0);
    drive(3'd3, 1'b1, D_NZERO, D_ZERO, D_ZERO, 1'b0, 1'b0);
    expect3("R4 0/0", 1'b1, 1'b0, 1'b0);
    drive(3'd3, 1'b0, sp(S_ZERO), sp(S_DEN), 64'h0, 1'b0, 1'b0);
    expect3("R4 0/subnormal", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_sqrt;
    drive(3'd4, 1'b0, sp(S_NONE), 64'h0, 64'h0, 1'b0, 1'b0);
    expect3("R5 sqrt -1", 1'b1, 1'b0, 1'b0);
    drive(3'd4, 1'b1, D_NINF, D_ZERO, D_ZERO, 1'b0, 1'b0);
    expect3("R5 sqrt -inf", 1'b1, 1'b0, 1'b0);
    drive(3'd4, 1'b1, D_NZERO, D_ZERO, D_ZERO, 1'b0, 1'b0);
    expect3("R5 sqrt -0", 1'b0, 1'b0, 1'b0);
    drive(3'd4, 1'b0, sp(S_ONE), 64'h0, 64'h0, 1'b0, 1'b0);
    expect3("R5 sqrt 1", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_fmaInvalid;
    drive(3'd5, 1'b0, sp(S_INF), sp(S_ZERO), sp(S_ONE), 1'b0, 1'b0);
    expect3("R6 inf*0+1", 1'b1, 1'b0, 1'b0);
    drive(3'd5, 1'b1, D_ONE, D_INF, D_NINF, 1'b0, 1'b0);
    expect3("R6 -inf+(+inf)", 1'b1, 1'b0, 1'b0);
    drive(3'd5, 1'b1, D_NONE, D_INF, D_INF, 1'b0, 1'b0);
    expect3("R6 inf+(-inf)", 1'b1, 1'b0, 1'b0);
    drive(3'd5, 1'b1, D_NONE, D_INF, D_NINF, 1'b0, 1'b0);
    expect3("R6 same sign", 1'b0, 1'b0, 1'b0);
    drive(3'd5, 1'b0, sp(S_ZERO), sp(S_INF), sp(S_ZERO), 1'b0, 1'b0);
    expect3("R6 0*inf+0 over zero rule", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_fmaExactZero;
    drive(3'd5, 1'b0, sp(S_NZERO), sp(S_ONE), sp(S_NZERO), 1'b0, 1'b0);
    expect3("R7 -0 + -0*1", 1'b0, 1'b1, 1'b1);
    drive(3'd5, 1'b0, sp(S_NZERO), sp(S_ONE), sp(S_ZERO), 1'b0, 1'b0);
    expect3("R7 +0 + -0*1", 1'b0, 1'b1, 1'b0);
    drive(3'd5, 1'b1, D_ZERO, D_ZERO, D_NZERO, 1'b0, 1'b0);
    expect3("R7 -0 + 0*0", 1'b0, 1'b1, 1'b0);
    drive(3'd1, 1'b0, sp(S_ZERO), sp(S_ZERO), sp(S_ZERO), 1'b0, 1'b1);
    expect3("R7 not for sub", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_fmaRoundZero;
    drive(3'd5, 1'b0, sp(S_ONE), sp(S_NONE), sp(S_ZERO), 1'b0, 1'b1);
    expect3("R8 neg product", 1'b0, 1'b1, 1'b1);
    drive(3'd5, 1'b1, D_NONE, D_NONE, D_NZERO, 1'b0, 1'b1);
    expect3("R8 pos product", 1'b0, 1'b1, 1'b0);
    drive(3'd5, 1'b1, D_NONE, D_NONE, D_ONE, 1'b0, 1'b1);
    expect3("R8 nonzero addend", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_nan;
    drive(3'd0, 1'b0, sp(S_INF), sp(S_NINF), 64'h0, 1'b1, 1'b0);
    expect3("R9 nanTaken", 1'b0, 1'b0, 1'b0);
    drive(3'd5, 1'b0, sp(S_INF), sp(S_ZERO), sp(S_QNAN), 1'b0, 1'b0);
    expect3("R9 qNaN addend", 1'b0, 1'b0, 1'b0);
    drive(3'd5, 1'b1, D_ZERO, D_ONE, D_QNAN, 1'b0, 1'b0);
    expect3("R9 NaN blocks zero", 1'b0, 1'b0, 1'b0);
    drive(3'd2, 1'b0, sp(S_SNAN), sp(S_ZERO), 64'h0, 1'b0, 1'b0);
    expect3("R9 sNaN factor", 1'b0, 1'b0, 1'b0);
    drive(3'd2, 1'b0, sp(S_INF), sp(S_ZERO), sp(S_QNAN), 1'b0, 1'b0);
    expect3("R9 unused opC NaN", 1'b1, 1'b0, 1'b0);
  endtask

  task automatic t_defaultNan;
    drive(3'd0, 1'b1, D_ZERO, D_ZERO, D_ZERO, 1'b0, 1'b0);
    expectNan("R10 double", 64'h7FF8000000000000);
    drive(3'd0, 1'b0, 64'h0, 64'h0, 64'h0, 1'b0, 1'b0);
    expectNan("R10 single", 64'h000000007FC00000);
    drive(3'd0, 1'b0, {S_INF, S_ONE}, {S_NINF, S_ONE}, 64'h0, 1'b0, 1'b0);
    expect3("R10 upper half ignored", 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_reserved;
    drive(3'd6, 1'b0, sp(S_INF), sp(S_ZERO), sp(S_ZERO), 1'b0, 1'b1);
    expect3("R11 opcode 6", 1'b0, 1'b0, 1'b0);
    drive(3'd7, 1'b1, D_NINF, D_ZERO, D_ZERO, 1'b0, 1'b1);
    expect3("R11 opcode 7", 1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    opA = '0; opB = '0; opC = '0; opcode = '0;
    dblSel = 1'b0; nanTaken = 1'b0; prodRoundedZero = 1'b0;
    t_idle();
    t_add();
    t_sub();
    t_mul();
    t_div();
    t_sqrt();
    t_fmaInvalid();
    t_fmaExactZero();
    t_fmaRoundZero();
    t_nan();
    t_defaultNan();
    t_reserved();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    #100000;
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule